// File: doc/BRIEF.md
# Serial Video Scrambler and NRZI Encoder

This block sits in a serial digital video transmit path just ahead of a serializer. It accepts one 10-bit parallel word per valid clock and, when two static strap inputs select serial-video mode, encodes the word in two steps. First it scrambles the word with a self-synchronizing scrambler (x^9 + x^4 + 1). Then it applies NRZ-to-NRZI coding (x + 1). The 10-bit result is presented with bit 0 as the first bit to be shifted out.

When the remap enable is high in serial-video mode, timing reference preambles captured from an 8-bit source are widened to 10-bit form before scrambling. An 8-bit source places its word in bits 9:2. In every other strap combination the word passes through untouched, and the latency is the same as on the encoded path.

The remap is a four-state machine:
- WAIT_HDR is the reset and idle state.
- SEEN_ONES is entered on any word whose bits 9:2 are all ones.
- SEEN_ZERO1 is entered from SEEN_ONES on a word whose bits 9:2 are zero.
- AT_XYZ is entered from SEEN_ZERO1 on a second such zero word.

The transitions are:
- An all-ones word in any state except AT_XYZ goes to SEEN_ONES.
- Any other word from SEEN_ONES or SEEN_ZERO1 returns to WAIT_HDR.
- AT_XYZ always returns to WAIT_HDR after one word.
- The machine is forced to WAIT_HDR whenever remapping is disabled.

The mode decode has three modes:
- VIDEO: scramble strap high, alternate strap low.
- RAW: scramble strap low, alternate strap low.
- ALT: alternate strap high, whatever the scramble strap.

Top module: `sdi_scr_tx`

## Requirements
- R1: With the alternate strap high, each valid word leaves unchanged, whatever the scramble strap and remap enable.
- R2: With the scramble strap low and the alternate strap low, each valid word leaves unchanged, and no remap is applied.
- R3: `dout_vld_o` equals `vld_i` delayed by exactly two clocks in every mode, and a valid output word belongs to the input word accepted two clocks earlier.
- R4: In VIDEO mode, each input bit b (bit 0 first) gives scrambled bit s = b ^ s(-4) ^ s(-9). Each output bit is then s XOR the previous output bit.
- R5: After reset both outputs are zero, and the scrambler and NRZI history start at zero. A first word 0x001 therefore leaves as 0x10F.
- R6: In VIDEO mode with remap enabled, a word whose bits 9:2 are 0xFF is replaced by 0x3FF. This applies in WAIT_HDR, SEEN_ONES and SEEN_ZERO1.
- R7: With remap active, a word whose bits 9:2 are zero is replaced by 0x000 only directly after an all-ones word or after one such replaced zero.
- R8: With remap active, the word after the second preamble zero keeps bits 9:2, and its bits 1:0 are cleared.
- R9: With the remap enable low, preamble-like words are scrambled unchanged.
- R10: Scrambler and NRZI history advance only on valid VIDEO words. Idle cycles and pass-through words leave them unchanged.
- R11: A preamble broken by any other word is not remapped, and later zero words are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vld_i | input | 1 | Input word valid |
| din_i | input | 10 | Parallel input word |
| scr_sel_i | input | 1 | Scramble strap (high selects VIDEO unless alternate strap high) |
| alt_sel_i | input | 1 | Alternate-protocol strap (high forces pass-through) |
| remap_en_i | input | 1 | Enables 8-to-10-bit preamble widening |
| dout_o | output | 10 | Encoded or passed word, bit 0 transmitted first |
| dout_vld_o | output | 1 | Output word valid |

## Verification
The bench targets the cases most likely to go wrong:
- Bit order and tap position. A design that scrambles MSB-first, or takes a tap one bit off, gives 0x10F wrong for the first word after reset, and every later word diverges too.
- Broken preambles and the XYZ padding. A machine that fails to drop back to WAIT_HDR would zero ordinary data words; one that forgets the pad would send 8-bit XYZ words with junk low bits.
- Gaps in the valid stream and mode switches mid-stream. History that advances on idle or pass-through cycles desynchronizes the receiver's descrambler for every word that follows.
- The two pass-through strap combinations. These show whether the pass path picks up remapping or runs a clock early or late.

// File: rtl/sdi_tx_pkg.sv
package sdi_tx_pkg;

    typedef enum logic [1:0] {
        MODE_VIDEO = 2'd0,
        MODE_RAW   = 2'd1,
        MODE_ALT   = 2'd2
    } tx_mode_e;

    typedef enum logic [1:0] {
        WAIT_HDR   = 2'd0,
        SEEN_ONES  = 2'd1,
        SEEN_ZERO1 = 2'd2,
        AT_XYZ     = 2'd3
    } trs_state_e;

endpackage

// File: rtl/sdi_mode_dec.sv
module sdi_mode_dec
    import sdi_tx_pkg::*;
(
    input  logic     scr_sel_i,
    input  logic     alt_sel_i,
    output tx_mode_e mode_o
);

    always_comb begin
        unique case ({alt_sel_i, scr_sel_i})
            2'b01:   mode_o = MODE_VIDEO;
            2'b00:   mode_o = MODE_RAW;
            default: mode_o = MODE_ALT;
        endcase
    end

endmodule

// File: rtl/sdi_trs_widen.sv
module sdi_trs_widen
    import sdi_tx_pkg::*;
#(
    parameter int DW    = 10,
    parameter int PAD_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          take_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] word_o
);

    localparam int HI_W = DW - PAD_W;

    trs_state_e state_q, state_d;
    logic       hi_ones, hi_zero;

    assign hi_ones = &din_i[DW-1:PAD_W];
    assign hi_zero = ~|din_i[DW-1:PAD_W];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            state_q <= WAIT_HDR;
        end else if (take_i) begin
            state_q <= state_d;
        end
    end

    // next state and widened word
    always_comb begin
        state_d = state_q;
        word_o  = din_i;
        if (en_i) begin
            unique case (state_q)
                WAIT_HDR: begin
                    if (hi_ones) begin
                        word_o  = {DW{1'b1}};
                        state_d = SEEN_ONES;
                    end
                end
                SEEN_ONES, SEEN_ZERO1: begin
                    if (hi_zero) begin
                        word_o  = {DW{1'b0}};
                        state_d = (state_q == SEEN_ONES) ? SEEN_ZERO1 : AT_XYZ;
                    end else if (hi_ones) begin
                        word_o  = {DW{1'b1}};
                        state_d = SEEN_ONES;
                    end else begin
                        state_d = WAIT_HDR;
                    end
                end
                AT_XYZ: begin
                    word_o  = {din_i[DW-1:PAD_W], {PAD_W{1'b0}}};
                    state_d = WAIT_HDR;
                end
                default: state_d = WAIT_HDR;
            endcase
        end
    end

    // R6
    ones_widen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && take_i && state_q != AT_XYZ && hi_ones) |-> (word_o == {DW{1'b1}}));

    // R8
    xyz_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && take_i && state_q == AT_XYZ) |->
        (word_o[PAD_W-1:0] == '0 && word_o[DW-1:PAD_W] == din_i[DW-1:PAD_W]));

    // R9
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == WAIT_HDR));

    // R11
    broken_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && take_i && state_q == WAIT_HDR && !hi_ones) |-> (word_o == din_i));

    logic unused_hi;
    assign unused_hi = (HI_W < 1);

endmodule

// File: rtl/sdi_scr_nrzi.sv
module sdi_scr_nrzi #(
    parameter int DW      = 10,
    parameter int SCR_LEN = 9,
    parameter int SCR_TAP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] code_o
);

    localparam int TAP_IX = SCR_LEN - SCR_TAP;

    // hist: index 0 oldest scrambled bit, SCR_LEN-1 newest
    logic [SCR_LEN-1:0] hist_q, hist_c;
    logic               nrzi_q, nrzi_c;

    always_comb begin
        hist_c = hist_q;
        nrzi_c = nrzi_q;
        code_o = '0;
        for (int i = 0; i < DW; i++) begin
            hist_c    = {word_i[i] ^ hist_c[0] ^ hist_c[TAP_IX], hist_c[SCR_LEN-1:1]};
            nrzi_c    = nrzi_c ^ hist_c[SCR_LEN-1];
            code_o[i] = nrzi_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            nrzi_q <= 1'b0;
        end else if (adv_i) begin
            hist_q <= hist_c;
            nrzi_q <= nrzi_c;
        end
    end

    // R10
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> ($stable(hist_q) && $stable(nrzi_q)));

    // R4
    nrzi_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (nrzi_q == $past(code_o[DW-1])));

endmodule

// File: rtl/sdi_scr_tx.sv
module sdi_scr_tx
    import sdi_tx_pkg::*;
#(
    parameter int DW      = 10,
    parameter int PAD_W   = 2,
    parameter int SCR_LEN = 9,
    parameter int SCR_TAP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [DW-1:0] din_i,
    input  logic          scr_sel_i,
    input  logic          alt_sel_i,
    input  logic          remap_en_i,
    output logic [DW-1:0] dout_o,
    output logic          dout_vld_o
);

    tx_mode_e      mode;
    logic          video;
    logic [DW-1:0] wide_word;
    logic [DW-1:0] code_word;
    logic [DW-1:0] a_word;
    logic          a_vld, a_video;

    sdi_mode_dec u_mode (
        .scr_sel_i (scr_sel_i),
        .alt_sel_i (alt_sel_i),
        .mode_o    (mode)
    );

    assign video = (mode == MODE_VIDEO);

    sdi_trs_widen #(.DW(DW), .PAD_W(PAD_W)) u_widen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (video && remap_en_i),
        .take_i (vld_i),
        .din_i  (din_i),
        .word_o (wide_word)
    );

    // stage A: widened word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_vld   <= 1'b0;
            a_video <= 1'b0;
            a_word  <= '0;
        end else begin
            a_vld   <= vld_i;
            a_video <= video;
            if (vld_i) a_word <= wide_word;
        end
    end

    sdi_scr_nrzi #(.DW(DW), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (a_vld && a_video),
        .word_i (a_word),
        .code_o (code_word)
    );

    // stage B: output word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_vld_o <= 1'b0;
            dout_o     <= '0;
        end else begin
            dout_vld_o <= a_vld;
            if (a_vld) dout_o <= a_video ? code_word : a_word;
        end
    end

    // cycles since reset, for the two-deep history checks
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R3
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (dout_vld_o == $past(vld_i, 2)));

    // R2
    raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(vld_i, 2) && !$past(scr_sel_i, 2) && !$past(alt_sel_i, 2))
        |-> (dout_o == $past(din_i, 2)));

    // R1
    alt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(vld_i, 2) && $past(alt_sel_i, 2))
        |-> (dout_o == $past(din_i, 2)));

endmodule

// File: tb/sim_sdi_scr_tx.sv
module sim_sdi_scr_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vld = 1'b0;
    logic [9:0] din = '0;
    logic       scr_sel = 1'b0;
    logic       alt_sel = 1'b0;
    logic       remap_en = 1'b0;
    logic [9:0] dout;
    logic       dout_vld;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    sdi_scr_tx u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (vld),
        .din_i      (din),
        .scr_sel_i  (scr_sel),
        .alt_sel_i  (alt_sel),
        .remap_en_i (remap_en),
        .dout_o     (dout),
        .dout_vld_o (dout_vld)
    );

    // reference model state
    logic [8:0] mh;   // mh[0] newest scrambled bit
    logic       mq;
    int         pre;
    logic       p1v, p2v;
    logic [9:0] p1d, p2d;
    string      p1t, p2t;

    task automatic model_reset();
        mh = '0; mq = 1'b0; pre = 0;
        p1v = 1'b0; p2v = 1'b0; p1d = '0; p2d = '0; p1t = "R3"; p2t = "R3";
    endtask

    task automatic model_step(input logic v, input logic [9:0] w, input string tag);
        logic       vid;
        logic [9:0] rw, e;
        logic       b;
        vid = scr_sel && !alt_sel;
        rw  = w;
        if (!(vid && remap_en)) pre = 0;
        else if (v) begin
            case (pre)
                0: if (w[9:2] == 8'hFF) begin rw = 10'h3FF; pre = 1; end
                1, 2: begin
                    if (w[9:2] == 8'h00) begin rw = 10'h000; pre = pre + 1; end
                    else if (w[9:2] == 8'hFF) begin rw = 10'h3FF; pre = 1; end
                    else pre = 0;
                end
                default: begin rw = {w[9:2], 2'b00}; pre = 0; end
            endcase
        end
        e = rw;
        if (v && vid) begin
            for (int i = 0; i < 10; i++) begin
                b    = rw[i] ^ mh[8] ^ mh[3];
                mh   = {mh[7:0], b};
                mq   = mq ^ b;
                e[i] = mq;
            end
        end
        p2v = p1v; p2d = p1d; p2t = p1t;
        p1v = v;   p1d = e;   p1t = tag;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h", tag, act, exp);
        end
    endtask

    // drive one cycle (called at negedge), check at following negedge
    task automatic step(input logic v, input logic [9:0] w, input string tag);
        vld = v; din = w;
        @(posedge clk);
        model_step(v, w, tag);
        @(negedge clk);
        chk(dout_vld == p2v, p2t, int'(dout_vld), int'(p2v));
        if (p2v) chk(dout == p2d, p2t, int'(dout), int'(p2d));
    endtask

    task automatic flush(input string tag);
        step(1'b0, 10'h000, tag);
        step(1'b0, 10'h000, tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; vld = 1'b0; din = '0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        // R5: outputs zero after reset
        chk(dout == 10'h000, "R5", int'(dout), 0);
        chk(dout_vld == 1'b0, "R5", int'(dout_vld), 0);
    endtask

    task automatic t_first_word();
        scr_sel = 1'b1; alt_sel = 1'b0; remap_en = 1'b0;
        step(1'b1, 10'h001, "R5");
        step(1'b0, 10'h000, "R5");
        // R4/R5: hand-derived code of 0x001 from zero history
        chk(dout == 10'h10F, "R4", int'(dout), 'h10F);
        step(1'b0, 10'h000, "R3");
    endtask

    task automatic t_video_words();
        scr_sel = 1'b1; alt_sel = 1'b0; remap_en = 1'b0;
        step(1'b1, 10'h200, "R4");
        step(1'b1, 10'h155, "R4");
        step(1'b1, 10'h2AA, "R4");
        step(1'b1, 10'h3FF, "R4");
        step(1'b1, 10'h000, "R4");
        step(1'b1, 10'h0F0, "R4");
        step(1'b1, 10'h123, "R4");
        flush("R4");
    endtask

    task automatic t_preamble();
        scr_sel = 1'b1; alt_sel = 1'b0; remap_en = 1'b1;
        step(1'b1, 10'h040, "R6");
        step(1'b1, 10'h3FC, "R6");
        step(1'b1, 10'h001, "R7");
        step(1'b1, 10'h002, "R7");
        step(1'b1, 10'h2D3, "R8");
        step(1'b1, 10'h3FD, "R6");
        step(1'b1, 10'h3FE, "R6");
        step(1'b1, 10'h003, "R7");
        step(1'b0, 10'h000, "R7");
        step(1'b1, 10'h000, "R7");
        step(1'b1, 10'h281, "R8");
        flush("R8");
    endtask

    task automatic t_broken();
        scr_sel = 1'b1; alt_sel = 1'b0; remap_en = 1'b1;
        step(1'b1, 10'h3FC, "R11");
        step(1'b1, 10'h155, "R11");
        step(1'b1, 10'h002, "R11");
        step(1'b1, 10'h3FF, "R11");
        step(1'b1, 10'h001, "R11");
        step(1'b1, 10'h0AB, "R11");
        step(1'b1, 10'h003, "R11");
        flush("R11");
    endtask

    task automatic t_no_remap();
        scr_sel = 1'b1; alt_sel = 1'b0; remap_en = 1'b0;
        step(1'b1, 10'h3FD, "R9");
        step(1'b1, 10'h002, "R9");
        step(1'b1, 10'h001, "R9");
        step(1'b1, 10'h203, "R9");
        flush("R9");
    endtask

    task automatic t_pass_modes();
        scr_sel = 1'b0; alt_sel = 1'b0; remap_en = 1'b1;
        step(1'b1, 10'h3FD, "R2");
        step(1'b1, 10'h002, "R2");
        step(1'b1, 10'h001, "R2");
        step(1'b1, 10'h2D3, "R2");
        scr_sel = 1'b1; alt_sel = 1'b1;
        step(1'b1, 10'h3FC, "R1");
        step(1'b1, 10'h001, "R1");
        scr_sel = 1'b0;
        step(1'b1, 10'h2AA, "R1");
        step(1'b1, 10'h155, "R1");
        flush("R1");
    endtask

    task automatic t_gaps();
        scr_sel = 1'b1; alt_sel = 1'b0; remap_en = 1'b0;
        step(1'b1, 10'h111, "R10");
        step(1'b0, 10'h3C3, "R10");
        step(1'b1, 10'h222, "R10");
        step(1'b0, 10'h000, "R3");
        step(1'b0, 10'h000, "R3");
        step(1'b1, 10'h333, "R3");
        scr_sel = 1'b0;
        step(1'b1, 10'h0FF, "R10");
        step(1'b1, 10'h100, "R10");
        scr_sel = 1'b1;
        step(1'b1, 10'h044, "R10");
        step(1'b1, 10'h188, "R10");
        step(1'b0, 10'h000, "R3");
        step(1'b1, 10'h3A5, "R10");
        flush("R3");
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_first_word();
        t_video_words();
        t_preamble();
        t_broken();
        t_no_remap();
        t_pass_modes();
        t_gaps();
        t_reset();
        t_preamble();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R3: watchdog expired, actual 0x%03h expected 0x%03h", 0, 1);
            summary();
            $finish;
        end
    end

endmodule